// File: doc/BRIEF.md
# Dual Down-Counting Timer with APB Access

The block holds two identical programmable down-counters behind an APB slave port. Each counter has a load register, a current-value register, a control register and a sticky status flag. Software writes a start value, picks one-shot or periodic counting and starts the counter. The counter then steps down by one on every clock. When a running counter sits at zero, the block records a zero event. A one-shot counter stops there. A periodic counter reloads its load value and keeps going.

A join bit makes the two counters act as one double-width down-counter. The second counter holds the upper half and steps down only when the lower half wraps from zero. In this mode only the combined interrupt can fire. Every interrupt request is driven on two identical output vectors: one goes to the processor and one to the surrounding programmable logic.

The register word index is `paddr[5:2]`. Index 0 is load A and index 1 is value A (read only). Index 2 is control A and index 3 is status A. Indices 4 to 7 hold the same four registers for counter B. Index 8 is join, index 9 is the wide status, index 10 is the wide value low word, and index 11 is the wide value high shadow. Control bits are: bit 0 run, bit 1 one-shot (0 = periodic), bit 2 interrupt enable, and bit 3 reload strobe (write only, reads as 0). Status bit 0 is the sticky flag. Join bit 0 selects wide mode.

Top module: `dtimer_apb`

## Requirements
- R1: `pready` is always 1 and `pslverr` is always 0. A read of an index above 11, or of any address with `paddr` bits above bit 5 set, returns 0.
- R2: After reset, every register reads 0 and both interrupt vectors are 0.
- R3: A load write to a stopped counter also copies the value into the current value. A load write to a running counter changes only the load register.
- R4: A running counter whose value is not zero goes down by exactly one on each clock. A stopped counter holds its value.
- R5: In one-shot mode, a running counter at zero raises its flag and clears its run bit on the next clock. Its value stays 0.
- R6: In periodic mode, a running counter at zero reloads the load value on the next clock. A load of L therefore gives one zero event every L+1 clocks.
- R7: Writing control with bit 3 set copies the load value into the current value at once.
- R8: A status flag stays set until a write with bit 0 = 1 clears it. Writing bit 0 = 0 leaves the flag unchanged.
- R9: The interrupt bit for a counter equals its flag AND its enable bit. Bits [0], [1] and [2] are counter A, counter B and wide. `cpu_irq` and `fab_irq` are always equal.
- R10: With join = 1, control A drives a wide counter whose upper half is counter B and whose lower half is counter A. The upper half decrements when the lower half wraps from 0 to all ones.
- R11: With join = 1, the wide flag sets when both halves are zero while running. Interrupt bits [1:0] stay 0, and bit [2] equals the wide flag AND the enable bit of control A.
- R12: Reading the wide low word captures counter B into the shadow returned at index 11. A later change of counter B does not alter the shadow until the next low-word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | CNT_W | APB write data |
| prdata | output | CNT_W | APB read data |
| pready | output | 1 | Always high, zero wait states |
| pslverr | output | 1 | Always low |
| cpu_irq | output | 3 | Interrupts to processor: A, B, wide |
| fab_irq | output | 3 | Same interrupts to the logic fabric |

## Verification
The bench builds the block with its defaults: 32-bit counters and an 8-bit address. Small load values let one-shot stops, periodic reloads and zero events occur within a few clocks. Loading the upper half with 1 and the lower half with 2 makes the lower half wrap to all ones after three steps, which exercises the carry between halves and the shadow read. Address 0x80 reaches the upper-address-bit path of the unmapped read.

// File: rtl/dtimer_pkg.sv
// Shared register indices and control layout for the dual down-counter.
// Assumes word-aligned APB accesses; index is paddr[5:2].
package dtimer_pkg;
    localparam logic [3:0] IDX_JOIN  = 4'd8;
    localparam logic [3:0] IDX_WSTAT = 4'd9;
    localparam logic [3:0] IDX_WLO   = 4'd10;
    localparam logic [3:0] IDX_WHI   = 4'd11;
    localparam logic [3:0] IDX_LAST  = 4'd11;

    localparam int unsigned BIT_RUN    = 0;
    localparam int unsigned BIT_ONESHT = 1;
    localparam int unsigned BIT_IEN    = 2;
    localparam int unsigned BIT_RELOAD = 3;

    typedef struct packed {
        logic irq_en;
        logic oneshot;
        logic run;
    } tmr_ctrl_t;
endpackage

// File: rtl/dtimer_apb_if.sv
// APB decoder: turns a select/enable access into one-cycle write and read
// strobes plus a register word index. Assumes zero wait states.
module dtimer_apb_if #(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output logic              wr_en,
    output logic              rd_en,
    output logic              hit,
    output logic [3:0]        idx
);
    import dtimer_pkg::*;

    localparam int unsigned HI_W = ADDR_W - 6;

    // Decode the access phase and check the address falls in the map.
    always_comb begin
        idx   = paddr[5:2];
        hit   = (paddr[ADDR_W-1:6] == HI_W'(0)) && (idx <= IDX_LAST);
        wr_en = psel && penable && pwrite && hit;
        rd_en = psel && penable && !pwrite && hit;
    end
endmodule

// File: rtl/dtimer_count.sv
// One down-counter register. Priority: direct preload, then reload from the
// load value, then decrement. Wrap from zero is natural modulo arithmetic.
module dtimer_count #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             preload,
    input  logic [CNT_W-1:0] preload_val,
    input  logic             reload,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);
    // Counter update with fixed priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (preload) cnt <= preload_val;
        else if (reload)  cnt <= load_val;
        else if (dec)     cnt <= cnt - 1'b1;
    end

    // Zero detect used by the event logic.
    assign zero = (cnt == '0);

    AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !preload && !reload) |=> (cnt == $past(cnt) - 1'b1)); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec && !preload && !reload) |=> $stable(cnt)); // R4
endmodule

// File: rtl/dtimer_apb.sv
// Dual programmable down-counter timer with an APB slave port. The two
// counters run independently or, with the join bit, as one wide counter.
// Assumes a single clock and synchronous active-low reset; zero wait states.
module dtimer_apb #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [CNT_W-1:0]  pwdata,
    output logic [CNT_W-1:0]  prdata,
    output logic              pready,
    output logic              pslverr,
    output logic [2:0]        cpu_irq,
    output logic [2:0]        fab_irq
);
    import dtimer_pkg::*;

    localparam int unsigned NT = 2;

    logic                      wr_en, rd_en, hit;
    logic [3:0]                idx;
    logic [NT-1:0][CNT_W-1:0]  load_q;
    logic [NT-1:0][CNT_W-1:0]  cnt;
    tmr_ctrl_t [NT-1:0]        ctrl_q;
    logic [NT-1:0]             flag_q, zero;
    logic [NT-1:0]             wr_load, wr_ctrl, wr_stat, strobe_rel;
    logic [NT-1:0]             eff_run, evt, dec, reload, preload, stop_req;
    logic                      join_q, wflag_q, wevt;
    logic [CNT_W-1:0]          shadow_q;
    logic [2:0]                irq_vec;

    dtimer_apb_if #(.ADDR_W(ADDR_W)) u_if (
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .wr_en(wr_en), .rd_en(rd_en), .hit(hit), .idx(idx)
    );

    // Sequencing: decide decrement, reload and zero events per counter.
    always_comb begin
        wevt = 1'b0;
        for (int i = 0; i < NT; i++) begin
            wr_load[i]    = wr_en && (idx == 4'(4*i));
            wr_ctrl[i]    = wr_en && (idx == 4'(4*i+2));
            wr_stat[i]    = wr_en && (idx == 4'(4*i+3));
            strobe_rel[i] = wr_ctrl[i] && pwdata[BIT_RELOAD];
        end
        if (!join_q) begin
            for (int i = 0; i < NT; i++) begin
                eff_run[i]  = ctrl_q[i].run;
                evt[i]      = ctrl_q[i].run && zero[i];
                dec[i]      = ctrl_q[i].run && !zero[i];
                reload[i]   = (evt[i] && !ctrl_q[i].oneshot) || strobe_rel[i];
                stop_req[i] = evt[i] && ctrl_q[i].oneshot;
            end
        end else begin
            wevt        = ctrl_q[0].run && zero[0] && zero[1];
            eff_run     = {NT{ctrl_q[0].run}};
            evt         = '0;
            dec[0]      = ctrl_q[0].run && !wevt;
            dec[1]      = ctrl_q[0].run && zero[0] && !zero[1];
            reload      = {NT{(wevt && !ctrl_q[0].oneshot) || strobe_rel[0]}};
            stop_req[0] = wevt && ctrl_q[0].oneshot;
            stop_req[1] = 1'b0;
        end
        for (int i = 0; i < NT; i++) begin
            preload[i] = wr_load[i] && !eff_run[i];
        end
    end

    for (genvar g = 0; g < NT; g++) begin : g_tmr
        dtimer_count #(.CNT_W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n),
            .preload(preload[g]), .preload_val(pwdata),
            .reload(reload[g]), .load_val(load_q[g]),
            .dec(dec[g]), .cnt(cnt[g]), .zero(zero[g])
        );

        // Load register: written by software only.
        always_ff @(posedge clk) begin
            if (!rst_n)          load_q[g] <= '0;
            else if (wr_load[g]) load_q[g] <= pwdata;
        end

        // Control register: software write wins over a one-shot stop.
        always_ff @(posedge clk) begin
            if (!rst_n) ctrl_q[g] <= '0;
            else if (wr_ctrl[g]) begin
                ctrl_q[g].run     <= pwdata[BIT_RUN];
                ctrl_q[g].oneshot <= pwdata[BIT_ONESHT];
                ctrl_q[g].irq_en  <= pwdata[BIT_IEN];
            end else if (stop_req[g]) ctrl_q[g].run <= 1'b0;
        end

        // Sticky zero flag, write-one-to-clear, set wins.
        always_ff @(posedge clk) begin
            if (!rst_n) flag_q[g] <= 1'b0;
            else        flag_q[g] <= evt[g] | (flag_q[g] & !(wr_stat[g] && pwdata[0]));
        end
    end

    // Join bit, wide sticky flag and the high-word shadow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            join_q   <= 1'b0;
            wflag_q  <= 1'b0;
            shadow_q <= '0;
        end else begin
            if (wr_en && idx == IDX_JOIN) join_q <= pwdata[0];
            wflag_q <= wevt | (wflag_q & !(wr_en && idx == IDX_WSTAT && pwdata[0]));
            if (rd_en && idx == IDX_WLO) shadow_q <= cnt[1];
        end
    end

    // Read data mux; unmapped addresses read zero.
    always_comb begin
        prdata = '0;
        if (hit) begin
            case (idx)
                4'd0, 4'd4: prdata = load_q[idx[2]];
                4'd1, 4'd5: prdata = cnt[idx[2]];
                4'd2, 4'd6: prdata = CNT_W'(ctrl_q[idx[2]]);
                4'd3, 4'd7: prdata = CNT_W'(flag_q[idx[2]]);
                IDX_JOIN:   prdata = CNT_W'(join_q);
                IDX_WSTAT:  prdata = CNT_W'(wflag_q);
                IDX_WLO:    prdata = cnt[0];
                IDX_WHI:    prdata = shadow_q;
                default:    prdata = '0;
            endcase
        end
    end

    // Interrupt masking; split interrupts silenced in wide mode.
    always_comb begin
        irq_vec[0] = flag_q[0] & ctrl_q[0].irq_en & !join_q;
        irq_vec[1] = flag_q[1] & ctrl_q[1].irq_en & !join_q;
        irq_vec[2] = wflag_q & ctrl_q[0].irq_en & join_q;
    end

    assign cpu_irq = irq_vec;
    assign fab_irq = irq_vec;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    AST_BUS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        pready && !pslverr); // R1
    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req[0] && !wr_ctrl[0]) |=> !ctrl_q[0].run); // R5
    AST_ZERO_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        evt[0] |=> flag_q[0]); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[0] && !wr_stat[0]) |=> flag_q[0]); // R8
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[0].irq_en |-> !cpu_irq[0]); // R9
    AST_SPLIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        join_q |-> (cpu_irq[1:0] == 2'b00)); // R11
    AST_WIDE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        wevt |=> wflag_q); // R11
endmodule

// File: tb/dtimer_apb_tb.sv
module dtimer_apb_tb;
    localparam int CLK_PERIOD = 20;
    localparam int ADDR_W = 8;
    localparam int CNT_W  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [ADDR_W-1:0] paddr = '0;
    logic [CNT_W-1:0]  pwdata = '0;
    logic [CNT_W-1:0]  prdata;
    logic              pready, pslverr;
    logic [2:0]        cpu_irq, fab_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [CNT_W-1:0] exp_q[$];
    string            tag_q[$];
    event             mon_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtimer_apb #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .cpu_irq(cpu_irq), .fab_irq(fab_irq)
    );

    task automatic check(string tag, logic [CNT_W-1:0] got, logic [CNT_W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // Driver: one APB write, called and returning at a falling edge.
    task automatic apb_write(logic [ADDR_W-1:0] a, logic [CNT_W-1:0] d);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1'b1;
        @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    // Driver: push the expected read value, then run the read.
    task automatic apb_read(logic [ADDR_W-1:0] a, logic [CNT_W-1:0] e, string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        psel = 1'b1; pwrite = 1'b0; paddr = a;
        @(negedge clk); penable = 1'b1;
        #(CLK_PERIOD/4) -> mon_ev;
        @(negedge clk); psel = 1'b0; penable = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_irq(logic [2:0] e, string tag);
        check({tag, " cpu_irq"}, CNT_W'(cpu_irq), CNT_W'(e));
        check({tag, " fab_irq"}, CNT_W'(fab_irq), CNT_W'(e));
    endtask

    // Monitor: compare read data with the scoreboard front in the access phase.
    always @(mon_ev) begin
        logic [CNT_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, prdata, e);
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R2: reset state
        check_irq(3'b000, "R2 reset");
        apb_read(8'h00, 0, "R2 load A");
        apb_read(8'h04, 0, "R2 value A");
        apb_read(8'h18, 0, "R2 ctrl B");
        apb_read(8'h20, 0, "R2 join");
        // R1: bus handshake and unmapped reads
        check("R1 pready", CNT_W'(pready), 1);
        check("R1 pslverr", CNT_W'(pslverr), 0);
        apb_read(8'h38, 0, "R1 unmapped index");
        apb_read(8'h80, 0, "R1 unmapped high address");
        // R3: load while stopped copies into the value
        apb_write(8'h00, 100);
        apb_read(8'h04, 100, "R3 preload");
        // R4: five decrements between start and stop
        apb_write(8'h08, 1);
        idle(3);
        apb_write(8'h08, 0);
        apb_read(8'h04, 95, "R4 decrement");
        // R3: load while running leaves the value alone
        apb_write(8'h08, 1);
        apb_write(8'h00, 7);
        apb_write(8'h08, 0);
        apb_read(8'h04, 91, "R3 running load");
        apb_read(8'h00, 7, "R3 load register");
        // R7: reload strobe
        apb_write(8'h08, 32'h8);
        apb_read(8'h04, 7, "R7 reload strobe");
        // R5: one-shot stop with interrupt
        apb_write(8'h00, 3);
        apb_write(8'h08, 32'h7);
        idle(8);
        check_irq(3'b001, "R9 oneshot irq");
        apb_read(8'h0C, 1, "R5 flag");
        apb_read(8'h04, 0, "R5 held at zero");
        apb_read(8'h08, 6, "R5 run cleared");
        // R8: write-one-to-clear
        apb_write(8'h0C, 0);
        apb_read(8'h0C, 1, "R8 write zero keeps flag");
        apb_write(8'h0C, 1);
        apb_read(8'h0C, 0, "R8 write one clears");
        check_irq(3'b000, "R8 irq cleared");
        // R9: masked flag still sets
        apb_write(8'h10, 2);
        apb_write(8'h18, 3);
        idle(8);
        apb_read(8'h1C, 1, "R9 masked flag sets");
        check_irq(3'b000, "R9 masked");
        apb_write(8'h18, 4);
        check_irq(3'b010, "R9 enabled B");
        apb_write(8'h1C, 1);
        // R6: periodic reload, eight steps from 4
        apb_write(8'h00, 4);
        apb_write(8'h08, 1);
        idle(6);
        apb_write(8'h08, 0);
        apb_read(8'h04, 1, "R6 periodic reload");
        apb_read(8'h0C, 1, "R6 zero event");
        apb_write(8'h0C, 1);
        // R10: joined counter with carry
        apb_write(8'h18, 0);
        apb_write(8'h20, 1);
        apb_write(8'h00, 2);
        apb_write(8'h10, 1);
        apb_read(8'h04, 2, "R10 low preload");
        apb_read(8'h14, 1, "R10 high preload");
        apb_write(8'h08, 1);
        idle(2);
        apb_write(8'h08, 0);
        apb_read(8'h28, 32'hFFFF_FFFE, "R10 low wrapped");
        apb_read(8'h2C, 0, "R12 shadow high");
        apb_read(8'h14, 0, "R10 high borrowed");
        // R12: shadow holds until next low read
        apb_write(8'h10, 5);
        apb_read(8'h2C, 0, "R12 shadow stable");
        apb_read(8'h28, 32'hFFFF_FFFE, "R12 low read");
        apb_read(8'h2C, 5, "R12 shadow updated");
        // R11: wide zero event
        apb_write(8'h00, 1);
        apb_write(8'h10, 0);
        apb_write(8'h08, 32'h7);
        idle(6);
        check_irq(3'b100, "R11 wide irq");
        apb_read(8'h24, 1, "R11 wide flag");
        apb_read(8'h0C, 0, "R11 split flag quiet");
        apb_write(8'h24, 1);
        apb_read(8'h24, 0, "R11 wide flag cleared");
        check_irq(3'b000, "R11 irq cleared");
        idle(2);
        check("scoreboard drained", CNT_W'(exp_q.size()), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule